// File: doc/BRIEF.md
# Event Ring Byte Counter with Interrupt Moderation

This block keeps the fill level, in bytes, of a circular event buffer that lives in system memory. A producer port reports each event at the moment it is written into the ring, together with its length. Most events are four bytes long, and some take several four-byte entries. The block adds each accepted length to a running count.

Software drains the ring and then tells the block how many bytes it consumed. It does this by writing that number to the count register, and the block subtracts it from the count; the write does not overwrite the count. An interrupt line stays high while unread bytes remain, unless a mask bit blocks it. The mask stops only the interrupt: events are still counted while it is set.

An optional moderation mode adds a busy flag and a holdoff timer, so that the interrupt cannot fire again until software has cleared busy and the holdoff has run out. A small register port gives access to:
- the buffer size and the mask,
- the count and its flags,
- the two halves of the ring base address,
- the moderation setup.

Top module: `event_ring_counter`

## Requirements
- R1: After reset, the count, the overflow flag, the busy flag, the size, the mask, both address halves and the moderation setup are all zero, and `irq` is low.
- R2: An event offered on `evt_valid` with length `evt_bytes` is accepted (`evt_taken` high in that cycle) when it fits, and the count read at address 1, bits 15:0, rises by that length after the clock edge.
- R3: A write to address 1 subtracts `reg_wdata[15:0]` from the count. If the value written exceeds the count, the count becomes zero and never wraps.
- R4: When an event and a count write happen in the same cycle, both apply. The new count is the count minus the written bytes (clamped at zero) plus the event length.
- R5: An event is refused (`evt_taken` low, count unchanged) when the post-subtraction count plus its length would exceed the size field (address 0, bits 15:0). A refusal sets a sticky overflow flag at address 1, bit 16. Writing 1 to bit 16 of address 1 clears the flag. An event that exactly fills the size is accepted.
- R6: With moderation off, `irq` is high exactly while the count is non-zero and the mask (address 0, bit 31) is clear. It follows the count in the same cycle that the count register updates.
- R7: While the mask is set, `irq` stays low, and events are still accepted and counted.
- R8: With moderation enabled (address 4, bit 31), the busy flag (address 1, bit 31) is set on the clock edge after the count is non-zero, the mask is clear, busy is clear and the holdoff timer is zero. `irq` is high while busy is set, the count is non-zero and the mask is clear. `irq` is low while busy is clear.
- R9: Writing 1 to bit 31 of address 1 clears busy. When busy is set, the holdoff timer loads the value in address 4, bits 11:0, and then counts down once per cycle. Busy cannot be set again until the timer reaches zero.
- R10: Address 0 (size and mask), address 2 (base address low), address 3 (base address high) and address 4 (moderation) read back the values last written to them.
- R11: Addresses 5 to 7 read as zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | An event has been written to the ring this cycle |
| evt_bytes | input | CNT_W | Length of that event in bytes |
| evt_taken | output | 1 | The event is accepted (it fits within the size) |
| reg_addr | input | 3 | Register select for reads and writes |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |

## Verification
Directed sequences each separate one rule from its neighbours:
- A decrement larger than the count separates clamping from wraparound.
- An event that exactly fills the ring, followed by one that would overshoot it, pins the comparison at the size boundary.
- A masked phase checks that counting continues while the interrupt stays low.
- A moderation run counts the idle cycles between clearing busy and the next interrupt, which separates a holdoff that starts when busy is set from one that starts when busy is cleared.

A long random phase then mixes events of one to four entries, decrements, flag clears, size changes and moderation setups against a cycle model in the bench. This exposes interactions such as an event and a decrement in the same cycle, or a rearm that coincides with a clear.

// File: rtl/event_ring_counter.sv
module event_ring_counter #(
  parameter int CNT_W  = 16,
  parameter int HOLD_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             evt_valid,
  input  logic [CNT_W-1:0] evt_bytes,
  output logic             evt_taken,
  input  logic [2:0]       reg_addr,
  input  logic             reg_wr,
  input  logic [31:0]      reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             irq
);
  localparam logic [2:0] A_SIZE = 3'd0, A_COUNT = 3'd1, A_LO = 3'd2,
                         A_HI = 3'd3, A_MOD = 3'd4;

  logic [CNT_W-1:0]  size_q, count_q;
  logic              mask_q, ovf_q, busy_q, mod_en_q;
  logic [31:0]       lo_q, hi_q;
  logic [HOLD_W-1:0] hold_q, holdv_q;

  wire              wr_cnt  = reg_wr && (reg_addr == A_COUNT);
  wire [CNT_W-1:0]  dec     = wr_cnt ? reg_wdata[CNT_W-1:0] : '0;
  wire [CNT_W-1:0]  base    = (dec > count_q) ? '0 : count_q - dec;
  wire [CNT_W:0]    sum     = {1'b0, base} + {1'b0, evt_bytes};
  wire              pending = (count_q != '0);
  wire              arm     = mod_en_q && pending && !mask_q && !busy_q && (hold_q == '0);

  assign evt_taken = evt_valid && (sum <= {1'b0, size_q});
  assign irq       = pending && !mask_q && (!mod_en_q || busy_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      size_q   <= '0;
      count_q  <= '0;
      mask_q   <= 1'b0;
      ovf_q    <= 1'b0;
      busy_q   <= 1'b0;
      mod_en_q <= 1'b0;
      lo_q     <= '0;
      hi_q     <= '0;
      hold_q   <= '0;
      holdv_q  <= '0;
    end else begin
      count_q <= evt_taken ? sum[CNT_W-1:0] : base;

      if (evt_valid && !evt_taken)         ovf_q <= 1'b1;
      else if (wr_cnt && reg_wdata[16])    ovf_q <= 1'b0;

      if (arm)                             busy_q <= 1'b1;
      else if (wr_cnt && reg_wdata[31])    busy_q <= 1'b0;

      if (arm)                             hold_q <= holdv_q;
      else if (hold_q != '0)               hold_q <= hold_q - HOLD_W'(1);

      if (reg_wr) begin
        case (reg_addr)
          A_SIZE: begin
            size_q <= reg_wdata[CNT_W-1:0];
            mask_q <= reg_wdata[31];
          end
          A_LO:  lo_q <= reg_wdata;
          A_HI:  hi_q <= reg_wdata;
          A_MOD: begin
            holdv_q  <= reg_wdata[HOLD_W-1:0];
            mod_en_q <= reg_wdata[31];
          end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_SIZE: begin
        reg_rdata[CNT_W-1:0] = size_q;
        reg_rdata[31]        = mask_q;
      end
      A_COUNT: begin
        reg_rdata[CNT_W-1:0] = count_q;
        reg_rdata[16]        = ovf_q;
        reg_rdata[31]        = busy_q;
      end
      A_LO:  reg_rdata = lo_q;
      A_HI:  reg_rdata = hi_q;
      A_MOD: begin
        reg_rdata[HOLD_W-1:0] = holdv_q;
        reg_rdata[31]         = mod_en_q;
      end
      default: ;
    endcase
  end

  a_r6_irq_needs_pending: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (count_q != '0));
  a_r7_mask_blocks_irq: assert property (@(posedge clk) disable iff (!rst_n)
    mask_q |-> !irq);
  a_r8_irq_waits_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && mod_en_q) |-> busy_q);
  a_r5_refusal_sticks: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_valid && !evt_taken) |=> ovf_q);
  a_r3_no_wrap_up: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_cnt && !evt_valid) |=> (count_q <= $past(count_q)));
  a_r9_no_rearm_in_holdoff: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_q && hold_q != '0) |=> !busy_q);
endmodule

// File: tb/event_ring_counter_test.sv
module event_ring_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 16;
  localparam int HW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic evt_valid = 1'b0, evt_taken, reg_wr = 1'b0, irq;
  logic [CW-1:0] evt_bytes = '0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0, reg_rdata;

  int checks = 0, errors = 0;

  event_ring_counter #(.CNT_W(CW), .HOLD_W(HW)) uut (
    .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_bytes(evt_bytes),
    .evt_taken(evt_taken), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  logic [15:0] m_count, m_size;
  logic [11:0] m_hold, m_holdv;
  logic m_mask, m_ovf, m_busy, m_moden;
  logic [31:0] m_lo, m_hi;

  function automatic logic [15:0] m_base();
    logic [15:0] d;
    d = (reg_wr && reg_addr == 3'd1) ? reg_wdata[15:0] : 16'd0;
    return (d > m_count) ? 16'd0 : m_count - d;
  endfunction

  function automatic logic m_taken();
    logic [16:0] s;
    s = {1'b0, m_base()} + {1'b0, evt_bytes};
    return evt_valid && (s <= {1'b0, m_size});
  endfunction

  function automatic logic m_irq();
    return (m_count != 0) && !m_mask && (!m_moden || m_busy);
  endfunction

  function automatic logic [31:0] m_rd(input logic [2:0] a);
    case (a)
      3'd0: return {m_mask, 15'd0, m_size};
      3'd1: return {m_busy, 14'd0, m_ovf, m_count};
      3'd2: return m_lo;
      3'd3: return m_hi;
      3'd4: return {m_moden, 19'd0, m_holdv};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string rd_tag(input logic [2:0] a);
    case (a)
      3'd0, 3'd2, 3'd3: return "R10";
      3'd1: return "R2";
      3'd4: return "R8";
      default: return "R11";
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_count <= 0; m_size <= 0; m_hold <= 0; m_holdv <= 0;
      m_mask <= 0; m_ovf <= 0; m_busy <= 0; m_moden <= 0;
      m_lo <= 0; m_hi <= 0;
    end else begin
      logic tk, arm, wc;
      tk  = m_taken();
      arm = m_moden && m_count != 0 && !m_mask && !m_busy && m_hold == 0;
      wc  = reg_wr && reg_addr == 3'd1;
      m_count <= tk ? m_base() + evt_bytes : m_base();
      if (evt_valid && !tk) m_ovf <= 1'b1;
      else if (wc && reg_wdata[16]) m_ovf <= 1'b0;
      if (arm) m_busy <= 1'b1;
      else if (wc && reg_wdata[31]) m_busy <= 1'b0;
      if (arm) m_hold <= m_holdv;
      else if (m_hold != 0) m_hold <= m_hold - 12'd1;
      if (reg_wr) begin
        if (reg_addr == 3'd0) begin m_size <= reg_wdata[15:0]; m_mask <= reg_wdata[31]; end
        if (reg_addr == 3'd2) m_lo <= reg_wdata;
        if (reg_addr == 3'd3) m_hi <= reg_wdata;
        if (reg_addr == 3'd4) begin m_holdv <= reg_wdata[11:0]; m_moden <= reg_wdata[31]; end
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic ev, input logic [15:0] eb, input logic wr,
                      input logic [2:0] a, input logic [31:0] wd);
    evt_valid = ev; evt_bytes = eb; reg_wr = wr; reg_addr = a; reg_wdata = wd;
    #1;
    chk(evt_taken == m_taken(), "R5 evt_taken", {31'd0, evt_taken}, {31'd0, m_taken()});
    @(negedge clk);
    chk(irq == m_irq(), "R6 R8 irq", {31'd0, irq}, {31'd0, m_irq()});
    chk(reg_rdata == m_rd(a), rd_tag(a), reg_rdata, m_rd(a));
    evt_valid = 0; reg_wr = 0;
  endtask

  task automatic peek(input logic [2:0] a, input logic [31:0] exp, input string tag);
    step(0, 0, 0, a, 0);
    chk(reg_rdata == exp, tag, reg_rdata, exp);
  endtask

  task automatic irq_is(input logic exp, input string tag);
    chk(irq == exp, tag, {31'd0, irq}, {31'd0, exp});
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++; errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    peek(3'd1, 32'h0, "R1 count");
    peek(3'd0, 32'h0, "R1 size");
    peek(3'd4, 32'h0, "R1 moderation");
    irq_is(1'b0, "R1 irq");

    step(0, 0, 1, 3'd0, 32'h0000_0040);
    step(1, 8, 0, 3'd1, 0);
    peek(3'd1, 32'd8, "R2 count after 8");
    irq_is(1'b1, "R6 irq with pending");
    step(1, 12, 0, 3'd1, 0);
    peek(3'd1, 32'd20, "R2 count after 12");
    step(0, 0, 1, 3'd1, 32'd5);
    peek(3'd1, 32'd15, "R3 subtract");
    step(0, 0, 1, 3'd1, 32'd100);
    peek(3'd1, 32'd0, "R3 clamp");
    irq_is(1'b0, "R6 irq empty");
    step(1, 16, 0, 3'd1, 0);
    step(1, 8, 1, 3'd1, 32'd4);
    peek(3'd1, 32'd20, "R4 simultaneous");
    step(1, 48, 0, 3'd1, 0);
    chk(reg_rdata == 32'h0001_0014, "R5 refused", reg_rdata, 32'h0001_0014);
    step(0, 0, 1, 3'd1, 32'h0001_0000);
    peek(3'd1, 32'h14, "R5 clear flag");
    step(1, 44, 0, 3'd1, 0);
    peek(3'd1, 32'h40, "R5 exact fill");

    step(0, 0, 1, 3'd0, 32'h8000_0040);
    irq_is(1'b0, "R7 masked");
    step(0, 0, 1, 3'd1, 32'd8);
    step(1, 4, 0, 3'd1, 0);
    peek(3'd1, 32'd60, "R7 counts while masked");
    irq_is(1'b0, "R7 still masked");
    peek(3'd0, 32'h8000_0040, "R10 size readback");
    step(0, 0, 1, 3'd0, 32'h0000_0040);
    irq_is(1'b1, "R6 unmasked");

    step(0, 0, 1, 3'd4, 32'h8000_0005);
    irq_is(1'b0, "R8 before busy");
    peek(3'd1, 32'h8000_003C, "R8 busy set");
    irq_is(1'b1, "R8 irq with busy");
    step(0, 0, 1, 3'd1, 32'h8000_0000);
    irq_is(1'b0, "R9 busy cleared");
    for (int i = 0; i < 4; i++) begin
      step(0, 0, 0, 3'd1, 0);
      irq_is(1'b0, "R9 holdoff");
    end
    step(0, 0, 0, 3'd1, 0);
    irq_is(1'b1, "R9 rearm after holdoff");

    step(0, 0, 1, 3'd2, 32'h1234_5600);
    step(0, 0, 1, 3'd3, 32'hCAFE_0001);
    peek(3'd2, 32'h1234_5600, "R10 addr low");
    peek(3'd3, 32'hCAFE_0001, "R10 addr high");
    step(0, 0, 1, 3'd5, 32'hFFFF_FFFF);
    peek(3'd5, 32'h0, "R11 unmapped");
    peek(3'd1, m_rd(3'd1), "R11 count untouched");

    for (int n = 0; n < 4000; n++) begin
      logic [2:0] a;
      logic [31:0] wd;
      logic wr, ev;
      a  = 3'($urandom_range(0, 7));
      wr = ($urandom_range(0, 3) == 0);
      ev = ($urandom_range(0, 2) != 0);
      case (a)
        3'd0: wd = {($urandom_range(0, 5) == 0), 15'd0, 16'($urandom_range(0, 160))};
        3'd1: wd = {($urandom_range(0, 3) == 0), 14'd0, ($urandom_range(0, 3) == 0),
                    16'($urandom_range(0, 40))};
        3'd4: wd = {($urandom_range(0, 1) == 1), 19'd0, 12'($urandom_range(0, 9))};
        default: wd = $urandom;
      endcase
      step(ev, 16'(4 * $urandom_range(1, 4)), wr, a, wd);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule